// File: doc/BRIEF.md
# GPIO Pin Bank Controller with Interrupt Detection

This block controls a set of general-purpose pins arranged in banks of 32. Every pin owns a configuration word and an auxiliary word that are reached through a simple 32-bit register bus. The configuration word chooses the pin direction, push-pull or open-drain drive, the source of the output value, the function selection, the output polarity of an alternate function, input-pad gating and the interrupt-detect mode. Each bank also has four 32-bit words: the synchronized pad inputs, the parallel output values, the lock bits and the interrupt status.

The block drives a data value and an output enable for each pad. In open-drain mode a logic 1 output releases the pad. Alternate-function data arrives on an input port with seven lanes per pin. Each pin also has one interrupt status bit, and this bit appears on an output port. Pull, power-domain, drive-strength and slew settings are kept only as register bits.

A bus address is `{region[2:0], index}`. The index is a pin number for the per-pin regions and a bank number for the bank regions. Pin `p` belongs to bank `p / 32` and uses bit `p % 32` of that bank's words.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every configuration word reads 0x00008040 (input pad off, detection off). Auxiliary, parallel-output, lock and status words read 0. No pad output enable or pad data is asserted.
- R2: A configuration write stores only bits [16:0]. Bits [31:25] and [23:17] read 0. Bit 24 is read-only. An auxiliary write keeps only the bits in mask 0x31.
- R3: Configuration bit 24 and the pin's bit in the bank input word (region 2) show the pad level after a two-flop synchronizer. The value is still old after one clock edge and becomes new after the second. Both read 0 while bit 15 (input pad off) is set.
- R4: With function select bits [14:12] = 0, the output enable follows bit 9. The output value is bit 16 when bit 10 = 0, and it is the pin's parallel-output bit (region 3) when bit 10 = 1.
- R5: With function select n in 1..7, the output value is alternate lane n-1 of the pin XOR bit 11. Bit 11 has no effect while the function select is 0.
- R6: With bit 8 = 1 (open drain), pad data is always 0 and the output enable is bit 9 AND NOT value. With bit 8 = 0, pad data is the value and the output enable is bit 9.
- R7: Detect code 0x0 (level low) or 0x1 (level high) in bits [7:4] makes the status bit follow the condition on the synchronized input. The status is not held, and a write-1 clear leaves no lasting effect.
- R8: Detect codes 0xD (rising), 0xE (falling) and 0xF (both) set a held status bit on the matching edge of the synchronized input. Writing 1 to that bit in region 5 clears it, and writing 0 has no effect.
- R9: Detect code 0x4, any code not listed in R7 or R8, and an input pad that is switched off all prevent any new status from being set.
- R10: Lock bits (region 4) can only be set by a write. A later write of 0 does not clear them. Only reset clears them.
- R11: While a pin's lock bit is set, writes to its configuration word, its auxiliary word and its parallel-output bit are ignored. Writes to other pins still take effect.
- R12: Writes to the input word region are ignored. Reads of regions 6 and 7, or of a bank index at or above the bank count, return 0. Bank-region writes to such an index are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; commits on the rising clock edge |
| bus_addr | input | ADDR_W | {region[2:0], pin or bank index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NPINS | Raw pad input levels |
| alt_data | input | NPINS x 7 | Alternate-function output lanes per pin |
| pad_out | output | NPINS | Pad data to drive |
| pad_oe | output | NPINS | Pad output enable |
| irq_stat | output | NPINS | Per-pin interrupt status |

## Verification
The bench builds the block with two banks, which gives 64 pins and a 9-bit address. The test pins sit in the second bank, so the pin-to-bank split, the bank-relative bit positions and the rejection of bank indices past the last bank are all exercised. Seven alternate lanes are wired per pin, so the vector table reaches the lowest and highest function selections together with polarity and open-drain combinations.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_PINS = 32;
    localparam int CFG_W     = 17;
    localparam int AUX_W     = 6;
    localparam int NUM_ALT   = 7;

    localparam logic [CFG_W-1:0] CFG_RESET = 17'h08040;
    localparam logic [AUX_W-1:0] AUX_MASK  = 6'h31;

    // configuration word bit positions
    localparam int B_DET   = 4;
    localparam int B_OD    = 8;
    localparam int B_DIR   = 9;
    localparam int B_PSEL  = 10;
    localparam int B_POL   = 11;
    localparam int B_FSEL  = 12;
    localparam int B_INOFF = 15;
    localparam int B_OUTV  = 16;

    typedef enum logic [3:0] {
        DET_LOW  = 4'h0,
        DET_HIGH = 4'h1,
        DET_NONE = 4'h4,
        DET_RISE = 4'hD,
        DET_FALL = 4'hE,
        DET_BOTH = 4'hF
    } det_mode_e;

    typedef enum logic [2:0] {
        RG_CFG  = 3'd0,
        RG_AUX  = 3'd1,
        RG_PIN  = 3'd2,
        RG_POUT = 3'd3,
        RG_LOCK = 3'd4,
        RG_EVT  = 3'd5
    } region_e;

endpackage

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_raw,
    input  logic [3:0] mode,
    input  logic       pad_off,
    input  logic       clr,
    output logic       in_sync,
    output logic       stat
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic stat;
    } det_t;

    det_t q, d;
    logic rise, fall, held;

    always_comb begin
        d      = q;
        d.s1   = pad_raw;
        d.s2   = q.s1;
        d.prev = q.s2;
        rise   = q.s2 & ~q.prev & ~pad_off;
        fall   = ~q.s2 & q.prev & ~pad_off;
        held   = q.stat & ~clr;
        case (mode)
            DET_LOW:  d.stat = ~pad_off & ~q.s2;
            DET_HIGH: d.stat = ~pad_off & q.s2;
            DET_RISE: d.stat = held | rise;
            DET_FALL: d.stat = held | fall;
            DET_BOTH: d.stat = held | rise | fall;
            default:  d.stat = held;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_sync = q.s2 & ~pad_off;
    assign stat    = q.stat;

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_bank_pkg::*;
(
    input  logic [2:0]         fsel,
    input  logic               psel,
    input  logic               outv,
    input  logic               par_bit,
    input  logic               pol,
    input  logic               od,
    input  logic               dir,
    input  logic [NUM_ALT-1:0] alt,
    output logic               pad_out,
    output logic               pad_oe
);

    logic val;

    always_comb begin
        if (fsel == 3'd0) val = psel ? par_bit : outv;
        else              val = alt[fsel - 3'd1] ^ pol;
        if (od) begin
            pad_out = 1'b0;
            pad_oe  = dir & ~val;
        end else begin
            pad_out = val;
            pad_oe  = dir;
        end
    end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 3 + $clog2(32 * NUM_BANKS)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bus_wr,
    input  logic [ADDR_W-1:0]                      bus_addr,
    input  logic [31:0]                            bus_wdata,
    output logic [31:0]                            bus_rdata,
    input  logic [32*NUM_BANKS-1:0]                pad_in,
    input  logic [32*NUM_BANKS-1:0][NUM_ALT-1:0]   alt_data,
    output logic [32*NUM_BANKS-1:0]                pad_out,
    output logic [32*NUM_BANKS-1:0]                pad_oe,
    output logic [32*NUM_BANKS-1:0]                irq_stat
);

    localparam int NPINS = BANK_PINS * NUM_BANKS;
    localparam int PIN_W = $clog2(NPINS);

    typedef struct packed {
        logic [NPINS-1:0][CFG_W-1:0] cfg;
        logic [NPINS-1:0][AUX_W-1:0] aux;
        logic [NPINS-1:0]            pout;
        logic [NPINS-1:0]            lock;
    } regs_t;

    regs_t q, d;

    region_e            region;
    logic [PIN_W-1:0]   idx;
    logic [PIN_W-1:0]   base;
    logic               pin_hit;
    logic               bank_hit;
    logic [NPINS-1:0]   clr_v;

    // per-pin views shared with the bound checker
    logic [NPINS-1:0][CFG_W-1:0] cfg_v;
    logic [NPINS-1:0]            lock_v;
    logic [NPINS-1:0]            sync_v;
    logic [NPINS-1:0]            stat_v;
    logic [NPINS-1:0]            dir_v;
    logic [NPINS-1:0]            od_v;
    logic [NPINS-1:0]            off_v;
    logic [NPINS-1:0]            lvlhi_v;

    always_comb begin
        region   = region_e'(bus_addr[ADDR_W-1 -: 3]);
        idx      = bus_addr[PIN_W-1:0];
        pin_hit  = 32'(idx) < NPINS;
        bank_hit = 32'(idx) < NUM_BANKS;
        base     = PIN_W'(32'(idx) * BANK_PINS);
    end

    // next-state computation
    always_comb begin
        d     = q;
        clr_v = '0;
        if (bus_wr) begin
            case (region)
                RG_CFG: begin
                    if (pin_hit && !q.lock[idx])
                        d.cfg[idx] = bus_wdata[CFG_W-1:0];
                end
                RG_AUX: begin
                    if (pin_hit && !q.lock[idx])
                        d.aux[idx] = bus_wdata[AUX_W-1:0] & AUX_MASK;
                end
                RG_POUT: begin
                    if (bank_hit)
                        d.pout[base +: BANK_PINS] =
                            (q.pout[base +: BANK_PINS] & q.lock[base +: BANK_PINS]) |
                            (bus_wdata & ~q.lock[base +: BANK_PINS]);
                end
                RG_LOCK: begin
                    if (bank_hit)
                        d.lock[base +: BANK_PINS] = q.lock[base +: BANK_PINS] | bus_wdata;
                end
                RG_EVT: begin
                    if (bank_hit)
                        clr_v[base +: BANK_PINS] = bus_wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cfg: {NPINS{CFG_RESET}}, aux: '0, pout: '0, lock: '0};
        else        q <= d;
    end

    // per-pin detect and drive
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_raw (pad_in[i]),
            .mode    (q.cfg[i][B_DET +: 4]),
            .pad_off (q.cfg[i][B_INOFF]),
            .clr     (clr_v[i]),
            .in_sync (sync_v[i]),
            .stat    (stat_v[i])
        );

        gpio_pin_drive u_drv (
            .fsel    (q.cfg[i][B_FSEL +: 3]),
            .psel    (q.cfg[i][B_PSEL]),
            .outv    (q.cfg[i][B_OUTV]),
            .par_bit (q.pout[i]),
            .pol     (q.cfg[i][B_POL]),
            .od      (q.cfg[i][B_OD]),
            .dir     (q.cfg[i][B_DIR]),
            .alt     (alt_data[i]),
            .pad_out (pad_out[i]),
            .pad_oe  (pad_oe[i])
        );

        assign dir_v[i]   = q.cfg[i][B_DIR];
        assign od_v[i]    = q.cfg[i][B_OD];
        assign off_v[i]   = q.cfg[i][B_INOFF];
        assign lvlhi_v[i] = (q.cfg[i][B_DET +: 4] == DET_HIGH);
    end

    assign cfg_v    = q.cfg;
    assign lock_v   = q.lock;
    assign irq_stat = stat_v;

    // register read path
    always_comb begin
        bus_rdata = '0;
        case (region)
            RG_CFG:  if (pin_hit)  bus_rdata = {7'b0, sync_v[idx], 7'b0, q.cfg[idx]};
            RG_AUX:  if (pin_hit)  bus_rdata = 32'(q.aux[idx]);
            RG_PIN:  if (bank_hit) bus_rdata = sync_v[base +: BANK_PINS];
            RG_POUT: if (bank_hit) bus_rdata = q.pout[base +: BANK_PINS];
            RG_LOCK: if (bank_hit) bus_rdata = q.lock[base +: BANK_PINS];
            RG_EVT:  if (bank_hit) bus_rdata = stat_v[base +: BANK_PINS];
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NPINS-1:0][CFG_W-1:0] cfg,
    input logic [NPINS-1:0]            lock,
    input logic [NPINS-1:0]            dir,
    input logic [NPINS-1:0]            od,
    input logic [NPINS-1:0]            off,
    input logic [NPINS-1:0]            lvl_hi,
    input logic [NPINS-1:0]            in_sync,
    input logic [NPINS-1:0]            stat,
    input logic [NPINS-1:0]            pad_out,
    input logic [NPINS-1:0]            pad_oe
);

    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lock) & ~lock) == '0));

    p_od_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((od & pad_out) == '0));

    p_oe_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~dir) == '0));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
            lock[i] |=> $stable(cfg[i]));

        p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_hi[i] && !off[i]) |=> (stat[i] == $past(in_sync[i])));
    end

endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg_v),
    .lock    (lock_v),
    .dir     (dir_v),
    .od      (od_v),
    .off     (off_v),
    .lvl_hi  (lvlhi_v),
    .in_sync (sync_v),
    .stat    (stat_v),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/sim_gpio_pin_bank.sv
module sim_gpio_pin_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 2;
    localparam int NP   = 32 * NB;
    localparam int PW   = 6;
    localparam int AW   = 3 + PW;
    localparam int WDOG = 20000;
    localparam int NVEC = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pad_in = '0;
    logic [NP-1:0][6:0] alt_data = '0;
    logic [NP-1:0]     pad_out;
    logic [NP-1:0]     pad_oe;
    logic [NP-1:0]     irq_stat;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pin_bank #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .alt_data(alt_data), .pad_out(pad_out), .pad_oe(pad_oe), .irq_stat(irq_stat)
    );

    // {cfg[16:0], par, alt[6:0], exp_out, exp_oe, req[3:0]} applied to pin 37
    localparam logic [30:0] VEC [NVEC] = '{
        {17'h10240, 1'b0, 7'b0000000, 1'b1, 1'b1, 4'd4},  // R4 own bit high
        {17'h00240, 1'b0, 7'b0000000, 1'b0, 1'b1, 4'd4},  // R4 own bit low
        {17'h10040, 1'b0, 7'b0000000, 1'b1, 1'b0, 4'd4},  // R4 input direction
        {17'h00640, 1'b1, 7'b0000000, 1'b1, 1'b1, 4'd4},  // R4 parallel bit high
        {17'h10640, 1'b0, 7'b0000000, 1'b0, 1'b1, 4'd4},  // R4 parallel bit low
        {17'h10340, 1'b0, 7'b0000000, 1'b0, 1'b0, 4'd6},  // R6 open drain release
        {17'h00340, 1'b0, 7'b0000000, 1'b0, 1'b1, 4'd6},  // R6 open drain pull low
        {17'h01240, 1'b0, 7'b0000001, 1'b1, 1'b1, 4'd5},  // R5 function 1
        {17'h01A40, 1'b0, 7'b0000001, 1'b0, 1'b1, 4'd5},  // R5 function 1 inverted
        {17'h07240, 1'b0, 7'b1000000, 1'b1, 1'b1, 4'd5},  // R5 function 7
        {17'h03240, 1'b0, 7'b1111011, 1'b0, 1'b1, 4'd5},  // R5 function 3 lane low
        {17'h10A40, 1'b0, 7'b0000000, 1'b1, 1'b1, 4'd5},  // R5 polarity ignored in GPIO
        {17'h02340, 1'b0, 7'b0000010, 1'b0, 1'b0, 4'd6},  // R6 open drain with function 2
        {17'h00740, 1'b0, 7'b0000000, 1'b0, 1'b1, 4'd6}   // R6 open drain parallel low
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int rg, input int ix);
        return AW'((rg << PW) | ix);
    endfunction

    task automatic bus_write(input int rg, input int ix, input logic [31:0] dat);
        @(negedge clk);
        bus_addr  = addr_of(rg, ix);
        bus_wdata = dat;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic peek(input int rg, input int ix, output logic [31:0] dat);
        bus_addr = addr_of(rg, ix);
        #1;
        dat = bus_rdata;
    endtask

    task automatic bus_read(input int rg, input int ix, output logic [31:0] dat);
        @(negedge clk);
        peek(rg, ix, dat);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", WDOG, WDOG);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(0, 0, rd);  check("R1", rd, 32'h0000_8040);
        bus_read(0, 63, rd); check("R1", rd, 32'h0000_8040);
        bus_read(1, 10, rd); check("R1", rd, 32'h0);
        bus_read(3, 1, rd);  check("R1", rd, 32'h0);
        bus_read(4, 0, rd);  check("R1", rd, 32'h0);
        bus_read(5, 1, rd);  check("R1", rd, 32'h0);
        check("R1", 32'(|pad_oe), 32'h0);
        check("R1", 32'(|pad_out), 32'h0);
        check("R1", 32'(|irq_stat), 32'h0);

        // R2 write masks
        bus_write(0, 5, 32'hFFFF_FFFF);
        bus_read(0, 5, rd); check("R2", rd, 32'h0001_FFFF);
        check("R9", 32'(irq_stat[5]), 32'h0);
        bus_write(1, 5, 32'hFFFF_FFFF);
        bus_read(1, 5, rd); check("R2", rd, 32'h0000_0031);
        bus_write(0, 5, 32'h0000_8040);

        // R3 synchronizer latency and input gating
        bus_write(0, 2, 32'h0000_0040);
        @(negedge clk);
        pad_in[2] = 1'b1;
        @(negedge clk);
        peek(0, 2, rd); check("R3", rd, 32'h0000_0040);
        @(negedge clk);
        peek(0, 2, rd); check("R3", rd, 32'h0100_0040);
        bus_read(2, 0, rd); check("R3", rd, 32'h0000_0004);
        bus_write(0, 2, 32'h0000_8040);
        bus_read(0, 2, rd); check("R3", rd, 32'h0000_8040);
        bus_read(2, 0, rd); check("R3", rd, 32'h0);
        pad_in[2] = 1'b0;

        // R4 R5 R6 output vector table on pin 37
        for (int k = 0; k < NVEC; k++) begin
            logic [30:0] v;
            v = VEC[k];
            bus_write(3, 1, 32'(v[13]) << 5);
            alt_data[37] = v[12:6];
            bus_write(0, 37, 32'(v[30:14]));
            @(negedge clk);
            check($sformatf("R%0d", v[3:0]), {30'b0, pad_out[37], pad_oe[37]}, {30'b0, v[5], v[4]});
        end
        bus_write(0, 37, 32'h0000_8040);
        bus_write(3, 1, 32'h0);
        alt_data[37] = '0;

        // R7 level detection on pin 40 (bank 1 bit 8)
        bus_write(0, 40, 32'h0000_0010);
        settle(); check("R7", 32'(irq_stat[40]), 32'h0);
        pad_in[40] = 1'b1;
        settle(); check("R7", 32'(irq_stat[40]), 32'h1);
        bus_read(5, 1, rd); check("R7", rd, 32'h0000_0100);
        bus_write(5, 1, 32'h0000_0100);
        settle(); check("R7", 32'(irq_stat[40]), 32'h1);
        pad_in[40] = 1'b0;
        settle(); check("R7", 32'(irq_stat[40]), 32'h0);
        bus_write(0, 40, 32'h0000_0000);
        settle(); check("R7", 32'(irq_stat[40]), 32'h1);
        pad_in[40] = 1'b1;
        settle(); check("R7", 32'(irq_stat[40]), 32'h0);
        pad_in[40] = 1'b0;
        bus_write(0, 40, 32'h0000_8040);
        settle();

        // R8 edge detection on pin 41 (bank 1 bit 9)
        bus_write(0, 41, 32'h0000_00D0);
        settle(); check("R8", 32'(irq_stat[41]), 32'h0);
        pad_in[41] = 1'b1;
        settle(); check("R8", 32'(irq_stat[41]), 32'h1);
        bus_read(5, 1, rd); check("R8", rd, 32'h0000_0200);
        pad_in[41] = 1'b0;
        settle(); check("R8", 32'(irq_stat[41]), 32'h1);
        bus_write(5, 1, 32'h0);
        check("R8", 32'(irq_stat[41]), 32'h1);
        bus_write(5, 1, 32'h0000_0200);
        check("R8", 32'(irq_stat[41]), 32'h0);
        bus_write(0, 41, 32'h0000_00E0);
        pad_in[41] = 1'b1;
        settle(); check("R8", 32'(irq_stat[41]), 32'h0);
        pad_in[41] = 1'b0;
        settle(); check("R8", 32'(irq_stat[41]), 32'h1);
        bus_write(5, 1, 32'h0000_0200);
        bus_write(0, 41, 32'h0000_00F0);
        pad_in[41] = 1'b1;
        settle(); check("R8", 32'(irq_stat[41]), 32'h1);
        bus_write(5, 1, 32'h0000_0200);
        check("R8", 32'(irq_stat[41]), 32'h0);
        pad_in[41] = 1'b0;
        settle(); check("R8", 32'(irq_stat[41]), 32'h1);
        bus_write(5, 1, 32'h0000_0200);
        bus_write(0, 41, 32'h0000_8040);

        // R9 no new status when disabled, unknown code or pad off (pin 42)
        bus_write(0, 42, 32'h0000_0040);
        pad_in[42] = 1'b1; settle(); pad_in[42] = 1'b0; settle();
        check("R9", 32'(irq_stat[42]), 32'h0);
        bus_write(0, 42, 32'h0000_80F0);
        pad_in[42] = 1'b1; settle(); pad_in[42] = 1'b0; settle();
        check("R9", 32'(irq_stat[42]), 32'h0);
        bus_write(0, 42, 32'h0000_0070);
        pad_in[42] = 1'b1; settle(); pad_in[42] = 1'b0; settle();
        check("R9", 32'(irq_stat[42]), 32'h0);
        bus_write(0, 42, 32'h0000_8040);

        // R10 lock bits only set
        bus_write(4, 1, 32'h0000_1000);
        bus_read(4, 1, rd); check("R10", rd, 32'h0000_1000);
        bus_write(4, 1, 32'h0);
        bus_read(4, 1, rd); check("R10", rd, 32'h0000_1000);

        // R11 locked pin 44 ignores writes, neighbour pin 45 does not
        bus_write(0, 44, 32'h0001_0240);
        bus_read(0, 44, rd); check("R11", rd, 32'h0000_8040);
        check("R11", 32'(pad_oe[44]), 32'h0);
        bus_write(1, 44, 32'h0000_0031);
        bus_read(1, 44, rd); check("R11", rd, 32'h0);
        bus_write(3, 1, 32'hFFFF_FFFF);
        bus_read(3, 1, rd); check("R11", rd, 32'hFFFF_EFFF);
        bus_write(0, 45, 32'h0000_0240);
        bus_read(0, 45, rd); check("R11", rd, 32'h0000_0240);

        // R12 read-only and unmapped regions
        bus_write(2, 0, 32'hFFFF_FFFF);
        bus_read(2, 0, rd); check("R12", rd, 32'h0);
        bus_read(6, 0, rd); check("R12", rd, 32'h0);
        bus_read(7, 1, rd); check("R12", rd, 32'h0);
        bus_write(4, 3, 32'hFFFF_FFFF);
        bus_read(4, 3, rd); check("R12", rd, 32'h0);
        bus_read(4, 0, rd); check("R12", rd, 32'h0);
        bus_read(4, 1, rd); check("R12", rd, 32'h0000_1000);

        summary();
        $finish;
    end

endmodule